// File: doc/BRIEF.md
# Mask to Butterfly Control Decoder

This block turns a selection mask of `DATA_W` bits into the full set of switch controls for a lg(`DATA_W`)-stage butterfly routing network, `DATA_W/2` switches per stage. With those controls, a butterfly network followed by an AND with the mask scatters the low-order bits of a data word into the positions marked by ones. The same controls in reversed stage order drive an inverse butterfly network. Fed with the data already ANDed with the mask, that network gathers the marked bits to the low end.

A log-depth prefix population counter finds the number of mask ones at or below every position. A left-rotate-and-complement unit per subnetwork then turns two of those counts into that subnetwork's control field. The rotation that a plain recursive scheme would apply to the data between stages is folded into the controls instead. The counter results are registered, and then the control words are registered. A new mask is accepted every cycle and its controls appear two cycles later.

Top module: `bfly_mask_decoder`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after the second rising edge that follows, carrying that mask's controls. When `in_valid` is low, `out_valid` is low two edges later. Masks may arrive on consecutive cycles.
- R2: While `rst` is high at a rising edge, `out_valid`, `dep_ctrl` and `ext_ctrl` read zero after that edge.
- R3: Deposit network model. Stage s (0 first) pairs bit p with bit p+d, where d = `DATA_W`>>(s+1) and p has bit d clear. The switch uses control bit `dep_ctrl[s*DATA_W/2 + (p/(2d))*d + p%d]`, where 1 passes and 0 swaps. Applying all stages to data x and then ANDing with mask m gives the deposit of x under m: the i-th lowest one of m receives bit i of x, and all other bits are 0.
- R4: Field t of `ext_ctrl` (bits `t*DATA_W/2` upward, `DATA_W/2` wide) equals field lg(`DATA_W`)-1-t of `dep_ctrl`.
- R5: Extract network model. Stage t pairs bits a distance 2^t apart, using the same index rule with d = 2^t and field t of `ext_ctrl`. Applied to x AND m, it gives the extract of x under m: the bits of x at the ones of m packed in order at the low end, with zeros above them.
- R6: The lowest field of `dep_ctrl` holds ones in exactly its k lowest bits, where k is the number of ones in the lower half of the mask.
- R7: An all-zero mask yields all-zero control words, so both deposit and extract return zero for any data.
- R8: An all-ones mask yields all-one control words, so both networks return the data unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Mask on `mask_in` is to be decoded |
| mask_in | input | DATA_W | Selection mask, bit 0 rightmost |
| out_valid | output | 1 | Control words belong to a mask accepted two cycles earlier |
| dep_ctrl | output | DATA_W/2·lg(DATA_W) | Butterfly controls, stage 0 in the low field |
| ext_ctrl | output | DATA_W/2·lg(DATA_W) | Inverse butterfly controls, stage 0 in the low field |

## Verification
The hardest case to reach is a deep-stage subnetwork whose preceding ones count is not a multiple of its width. Only then does the rotate-and-complement unit wrap bits and invert them, and a mask with a balanced density rarely produces it in every stage at once. The stimulus therefore mixes sparse masks (ANDs of random words), dense masks (ORs of random words), and directed patterns such as a single top bit, alternating bits and one-sided halves. Each result is judged by running the emitted controls through a bench model of both networks and comparing the result with a direct scatter or gather of several data words. Random gaps in `in_valid` and a reset asserted while the pipeline is full cover the valid timing.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  // Width of a count that can reach n.
  function automatic int count_w(input int n);
    return $clog2(n) + 1;
  endfunction
endpackage

// File: rtl/bmd_prefix_count.sv
// Log-depth prefix population count: cnt_o slot p = ones in bits[p:0].
module bmd_prefix_count #(
  parameter int N  = 32,
  parameter int CW = 6
) (
  input  logic [N-2:0]        bits_i,
  output logic [(N-1)*CW-1:0] cnt_o
);
  localparam int LV = $clog2(N);
  localparam int P  = N - 1;

  logic [CW-1:0] lvl [0:LV][0:P-1];

  for (genvar p = 0; p < P; p++) begin : g_leaf
    assign lvl[0][p] = {{(CW-1){1'b0}}, bits_i[p]};
  end

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar p = 0; p < P; p++) begin : g_pos
      if (p >= (1 << l)) begin : g_add
        assign lvl[l+1][p] = lvl[l][p] + lvl[l][p-(1<<l)];
      end else begin : g_keep
        assign lvl[l+1][p] = lvl[l][p];
      end
    end
  end

  for (genvar p = 0; p < P; p++) begin : g_out
    assign cnt_o[p*CW +: CW] = lvl[LV][p];
  end
endmodule

// File: rtl/bmd_lrotc.sv
// Run of run_len low ones, rotated left by rot_amt with inversion on wrap.
module bmd_lrotc #(
  parameter int H  = 16,
  parameter int CW = 6
) (
  input  logic [CW-1:0]             run_len,
  input  logic [$clog2(2*H)-1:0]    rot_amt,
  output logic [H-1:0]              ctrl_o
);
  localparam int RW = $clog2(2*H);

  logic [H-1:0]   run;
  logic [2*H-1:0] dbl;

  always_comb begin
    for (int j = 0; j < H; j++) begin
      run[j] = (CW'(j) < run_len);
    end
    dbl = {~run, run};
    for (int j = 0; j < H; j++) begin
      ctrl_o[j] = dbl[RW'(j) - rot_amt];
    end
  end
endmodule

// File: rtl/bfly_mask_decoder.sv
module bfly_mask_decoder #(
  parameter  int DATA_W = 32,
  localparam int STAGES = $clog2(DATA_W),
  localparam int CTRL_W = (DATA_W / 2) * STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] mask_in,
  output logic              out_valid,
  output logic [CTRL_W-1:0] dep_ctrl,
  output logic [CTRL_W-1:0] ext_ctrl
);
  localparam int CW   = bmd_pkg::count_w(DATA_W);
  localparam int HALF = DATA_W / 2;
  localparam int PW   = (DATA_W - 1) * CW;

  // The top mask bit never changes any control.
  logic unused_top_bit;
  assign unused_top_bit = mask_in[DATA_W-1];

  // Pipeline stage 1: prefix counts.
  logic [PW-1:0] pfx_d, pfx_q;
  logic          v_q;

  bmd_prefix_count #(.N(DATA_W), .CW(CW)) u_pfx (
    .bits_i (mask_in[DATA_W-2:0]),
    .cnt_o  (pfx_d)
  );

  always_ff @(posedge clk) begin
    pfx_q <= pfx_d;
  end

  // Pipeline stage 2: one rotate-and-complement unit per subnetwork.
  logic [CTRL_W-1:0] dep_next, ext_next;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int H  = DATA_W >> (s + 1);
    localparam int RW = STAGES - s;
    for (genvar b = 0; b < (1 << s); b++) begin : g_sub
      localparam int BASE = b * 2 * H;
      logic [CW-1:0] below, upto, run_len;
      if (BASE == 0) begin : g_first
        assign below = '0;
      end else begin : g_rest
        assign below = pfx_q[(BASE-1)*CW +: CW];
      end
      assign upto    = pfx_q[(BASE+H-1)*CW +: CW];
      assign run_len = upto - below;

      bmd_lrotc #(.H(H), .CW(CW)) u_rot (
        .run_len (run_len),
        .rot_amt (below[RW-1:0]),
        .ctrl_o  (dep_next[s*HALF + b*H +: H])
      );
    end
  end

  for (genvar t = 0; t < STAGES; t++) begin : g_mirror
    assign ext_next[t*HALF +: HALF] = dep_next[(STAGES-1-t)*HALF +: HALF];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q       <= 1'b0;
      out_valid <= 1'b0;
      dep_ctrl  <= '0;
      ext_ctrl  <= '0;
    end else begin
      v_q       <= in_valid;
      out_valid <= v_q;
      dep_ctrl  <= dep_next;
      ext_ctrl  <= ext_next;
    end
  end
endmodule

// File: rtl/bmd_checker.sv
module bmd_checker #(
  parameter  int DATA_W = 32,
  localparam int STAGES = $clog2(DATA_W),
  localparam int CTRL_W = (DATA_W / 2) * STAGES,
  localparam int HALF   = DATA_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] mask_in,
  input logic              out_valid,
  input logic [CTRL_W-1:0] dep_ctrl,
  input logic [CTRL_W-1:0] ext_ctrl
);
  function automatic logic [HALF-1:0] low_run(input logic [DATA_W-1:0] m);
    int k;
    logic [HALF-1:0] r;
    k = $countones(m[HALF-1:0]);
    for (int j = 0; j < HALF; j++) r[j] = (j < k);
    return r;
  endfunction

  logic [CTRL_W-1:0] rev;
  for (genvar t = 0; t < STAGES; t++) begin : g_rev
    assign rev[t*HALF +: HALF] = dep_ctrl[(STAGES-1-t)*HALF +: HALF];
  end

  a_r1_valid_two_later: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);
  a_r1_idle_two_later: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);
  a_r2_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && dep_ctrl == '0 && ext_ctrl == '0));
  a_r4_reverse_order: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ext_ctrl == rev);
  a_r6_first_field: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> dep_ctrl[HALF-1:0] == low_run($past(mask_in, 2)));
  a_r7_zero_mask: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mask_in, 2) == '0) |-> (dep_ctrl == '0 && ext_ctrl == '0));
  a_r8_full_mask: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mask_in, 2) == '1) |-> (dep_ctrl == '1 && ext_ctrl == '1));
endmodule

bind bfly_mask_decoder bmd_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mask_in   (mask_in),
  .out_valid (out_valid),
  .dep_ctrl  (dep_ctrl),
  .ext_ctrl  (ext_ctrl)
);

// File: tb/bfly_mask_decoder_tb.sv
`timescale 1ns/1ps
module bfly_mask_decoder_tb;
  localparam int N    = 32;
  localparam int S    = 5;
  localparam int HALF = N / 2;
  localparam int CW   = HALF * S;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [N-1:0]  mask_in = '0;
  logic          out_valid;
  logic [CW-1:0] dep_ctrl, ext_ctrl;

  bfly_mask_decoder #(.DATA_W(N)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mask_in(mask_in),
    .out_valid(out_valid), .dep_ctrl(dep_ctrl), .ext_ctrl(ext_ctrl)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic         v_d1 = 1'b0, v_d2 = 1'b0;
  logic [N-1:0] m_d1 = '0, m_d2 = '0;

  function automatic logic [N-1:0] scatter(input logic [N-1:0] x, input logic [N-1:0] m);
    logic [N-1:0] y = '0;
    int k = 0;
    for (int i = 0; i < N; i++) if (m[i]) begin y[i] = x[k]; k++; end
    return y;
  endfunction

  function automatic logic [N-1:0] gather(input logic [N-1:0] x, input logic [N-1:0] m);
    logic [N-1:0] y = '0;
    int k = 0;
    for (int i = 0; i < N; i++) if (m[i]) begin y[k] = x[i]; k++; end
    return y;
  endfunction

  // fwd=1: butterfly, stage s distance N>>(s+1); fwd=0: inverse, distance 1<<t.
  function automatic logic [N-1:0] net_run(input logic [N-1:0] x, input logic [CW-1:0] c,
                                           input bit fwd);
    logic [N-1:0] y = x;
    for (int s = 0; s < S; s++) begin
      int d = fwd ? (N >> (s + 1)) : (1 << s);
      for (int p = 0; p < N; p++) begin
        if ((p & d) == 0) begin
          int idx = (p / (2 * d)) * d + (p % d);
          if (!c[s*HALF + idx]) begin
            logic t = y[p];
            y[p] = y[p+d];
            y[p+d] = t;
          end
        end
      end
    end
    return y;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [CW-1:0] act,
                     input logic [CW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic verify_out();
    logic [CW-1:0] mir;
    logic [HALF-1:0] run;
    int k;
    chk(out_valid === v_d2, "R1 out_valid", CW'(out_valid), CW'(v_d2));
    if (v_d2 && out_valid === 1'b1) begin
      for (int t = 0; t < S; t++) mir[t*HALF +: HALF] = dep_ctrl[(S-1-t)*HALF +: HALF];
      chk(ext_ctrl === mir, "R4 ext order", ext_ctrl, mir);
      k = $countones(m_d2[HALF-1:0]);
      for (int j = 0; j < HALF; j++) run[j] = (j < k);
      chk(dep_ctrl[HALF-1:0] === run, "R6 first field", CW'(dep_ctrl[HALF-1:0]), CW'(run));
      if (m_d2 == '0) begin
        chk(dep_ctrl === '0 && ext_ctrl === '0, "R7 zero mask ctrl", dep_ctrl, '0);
      end
      if (m_d2 == '1) begin
        chk(dep_ctrl === '1 && ext_ctrl === '1, "R8 full mask ctrl", dep_ctrl, '1);
      end
      for (int r = 0; r < 3; r++) begin
        logic [N-1:0] x, got, expv;
        x = (r == 0) ? '1 : N'($urandom);
        got  = m_d2 & net_run(x, dep_ctrl, 1'b1);
        expv = scatter(x, m_d2);
        chk(got === expv, (m_d2 == '0) ? "R7 deposit" : (m_d2 == '1) ? "R8 deposit" : "R3 deposit",
            CW'(got), CW'(expv));
        got  = net_run(x & m_d2, ext_ctrl, 1'b0);
        expv = gather(x, m_d2);
        chk(got === expv, (m_d2 == '0) ? "R7 extract" : (m_d2 == '1) ? "R8 extract" : "R5 extract",
            CW'(got), CW'(expv));
      end
    end
  endtask

  task automatic step(input logic v, input logic [N-1:0] m);
    @(negedge clk);
    verify_out();
    v_d2 = v_d1; m_d2 = m_d1;
    v_d1 = v;    m_d1 = m;
    in_valid = v;
    mask_in  = m;
  endtask

  task automatic check_reset_state(input string tag);
    chk(out_valid === 1'b0, tag, CW'(out_valid), '0);
    chk(dep_ctrl === '0, tag, dep_ctrl, '0);
    chk(ext_ctrl === '0, tag, ext_ctrl, '0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd8675309));
    repeat (3) @(negedge clk);
    check_reset_state("R2 reset state");
    rst = 1'b0;

    // Directed corner masks, back to back (R1 throughput, R7, R8).
    step(1'b1, '0);
    step(1'b1, '1);
    step(1'b1, 32'h0000_0001);
    step(1'b1, 32'h8000_0000);
    step(1'b1, 32'h5555_5555);
    step(1'b1, 32'hAAAA_AAAA);
    step(1'b1, 32'h0000_FFFF);
    step(1'b1, 32'hFFFF_0000);
    step(1'b1, 32'h8000_0001);
    step(1'b1, 32'h0F0F_7311);
    step(1'b0, 32'h1234_5678);
    step(1'b1, 32'h7FFF_FFFF);
    step(1'b0, '0);
    step(1'b0, '0);

    // Random masks of mixed density, with gaps in valid.
    for (int i = 0; i < 1500; i++) begin
      logic [N-1:0] m;
      case ($urandom % 4)
        0: m = N'($urandom);
        1: m = N'($urandom) & N'($urandom);
        2: m = N'($urandom) | N'($urandom);
        default: m = N'($urandom) & N'($urandom) & N'($urandom);
      endcase
      step(($urandom % 4) != 0, m);
    end

    // Reset with the pipeline full (R2), then confirm nothing emerges (R1).
    step(1'b1, 32'hDEAD_BEEF);
    step(1'b1, 32'h0BAD_F00D);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state("R2 reset mid-run");
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    v_d1 = 1'b0; v_d2 = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b0, '0);
    finish_run();
  end
endmodule